// File: doc/BRIEF.md
# Dual-Channel UART Interrupt Aggregator

This block gathers the interrupt sources of a two-channel UART (channel A for the console, channel B for the auxiliary port) into one interrupt request line to the CPU. It holds an interrupt status register and an interrupt mask register. A character arriving on a channel sets that channel's receive-ready status bit, but only when the matching mask bit is enabled. A timer tick input drives a small sequencer. On every second tick it sets the transmit-ready status bits of both channels together, provided at least one of the two transmit mask bits is enabled. These transmit events are synthesised and do not follow any real transmitter state.

The host clears status bits by writing ones to the status register, and it programs the mask by writing the mask register. The request line stays high for as long as any status bit is set under an enabled mask bit. The block also shows each channel's receive-ready and transmit-ready state as a small per-channel status byte.

Top module: `uart_irq_agg`

## Requirements
- R1: After a synchronous active-low reset, the status register, the mask register, both per-channel status bytes and `irq` are all zero. The tick sequencer count restarts at zero.
- R2: Status and mask share one bit layout: bit 0 is channel A transmit-ready (0x01), bit 1 is channel A receive-ready (0x02), bit 4 is channel B transmit-ready (0x10) and bit 5 is channel B receive-ready (0x20). All other bits always read 0, whatever value is written to them.
- R3: A receive event on a channel whose receive mask bit is set makes that receive-ready status bit read 1 on the edge that samples the event. `irq` is high from that edge on.
- R4: A receive event on a channel whose receive mask bit is clear leaves the status register unchanged.
- R5: The sequencer counts clock cycles with `tick` high and ignores all other cycles. Every second such tick it wraps to zero and fires. When it fires and mask bit 0 or mask bit 4 is set, status bits 0 and 4 both become 1 on that edge.
- R6: A firing tick with mask bits 0 and 4 both clear changes no status bit, and the count still wraps.
- R7: `irq` is the OR of the bitwise AND of status and mask. It stays high until the host clears those status bits or masks them off.
- R8: A write to the status register (`wr_en`=1, `wr_sel`=0) clears every status bit written as 1 and leaves the bits written as 0 unchanged.
- R9: A write to the mask register (`wr_en`=1, `wr_sel`=1) loads the mask on that edge. A receive event or tick in the same cycle is still judged against the old mask.
- R10: When a set event and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R11: The per-channel status byte has receive-ready at bit 0 (0x01), equal to the channel's receive-ready status bit, and transmit-ready at bit 2 (0x04), equal to its transmit-ready status bit. Its other bits are 0. Channel A is `chan_stat[7:0]` and channel B is `chan_stat[15:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_evt | input | 2 | Received-character pulses; bit 0 is channel A, bit 1 is channel B |
| tick | input | 1 | Timer tick, one cycle per tick |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 1 | Write target: 0 selects the status register (write-one-to-clear), 1 selects the mask register |
| wr_data | input | 8 | Host write data |
| isr | output | 8 | Interrupt status register |
| imr | output | 8 | Interrupt mask register |
| chan_stat | output | 16 | Per-channel status bytes, channel A in the low byte |
| irq | output | 1 | Combined interrupt request |

## Verification
Status and mask are registered, so they show the effect of a stimulus on the first clock edge that samples it. `irq` and the per-channel bytes are combinational from those registers, so they change in the same cycle. The bench drives every stimulus on a falling edge and compares all outputs on the next falling edge against a model it updates once per rising edge. In the sweep, every mask pattern of the four defined bits is combined with every pair of receive events, tick and no tick, and four host write variants (none, clear all, clear only the receive bits, same-cycle mask write). This covers the set-versus-clear and old-mask cases in every phase of the tick count.

// File: rtl/uart_irq_pkg.sv
// Package: shared constants and helpers for the UART interrupt aggregator.
// Assumes exactly two channels; bit layout of status/mask is fixed by the
// software-visible encoding.
package uart_irq_pkg;
    localparam int REG_W = 8;
    localparam int N_CH  = 2;
    localparam int CH_STRIDE = 4;

    // Positions of the per-channel flags inside the per-channel status byte.
    localparam int STAT_RX_POS = 0;
    localparam int STAT_TX_POS = 2;

    // Host write target selector.
    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;

    // Transmit-ready bit of channel ch in status/mask.
    function automatic int tx_pos(input int ch);
        return ch * CH_STRIDE;
    endfunction

    // Receive-ready bit of channel ch in status/mask.
    function automatic int rx_pos(input int ch);
        return ch * CH_STRIDE + 1;
    endfunction

    // Mask of all implemented status/mask bits.
    function automatic logic [REG_W-1:0] valid_bits();
        logic [REG_W-1:0] v;
        v = '0;
        for (int c = 0; c < N_CH; c++) begin
            v[tx_pos(c)] = 1'b1;
            v[rx_pos(c)] = 1'b1;
        end
        return v;
    endfunction

    // Mask of the transmit-ready bits only.
    function automatic logic [REG_W-1:0] tx_bits();
        logic [REG_W-1:0] v;
        v = '0;
        for (int c = 0; c < N_CH; c++) v[tx_pos(c)] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/uart_irq_tick_seq.sv
// Tick sequencer: counts timer ticks and produces a one-cycle fire strobe
// on every PERIOD-th tick, wrapping its count to zero at that moment.
// Assumes tick is a single-cycle pulse sampled on clk; PERIOD >= 2.
module uart_irq_tick_seq #(
    parameter int PERIOD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic fire
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    // Fire on the tick that completes a period.
    always_comb fire = tick && (cnt_q == LAST);

    // Advance the count on each tick, wrapping on fire.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (fire)     cnt_q <= '0;
        else if (tick)     cnt_q <= cnt_q + 1'b1;
    end

    // R5
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // R5
    cnt_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
endmodule

// File: rtl/uart_irq_regs.sv
// Status and mask register pair. Receive events and the tick fire strobe
// set status bits (subject to the mask held before this edge); host writes
// either clear status bits (write-one-to-clear) or load the mask. A set
// beats a clear of the same bit. Unimplemented bits are held at zero.
module uart_irq_regs
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CH-1:0]  rx_evt,
    input  logic             tx_fire,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] isr_q,
    output logic [REG_W-1:0] imr_q
);
    localparam logic [REG_W-1:0] VALID = valid_bits();
    localparam logic [REG_W-1:0] TXM   = tx_bits();

    logic [REG_W-1:0] rx_set;
    logic [REG_W-1:0] tx_set;
    logic [REG_W-1:0] clr_vec;
    logic             wr_status;
    logic             wr_mask;

    // Decode the host write target.
    always_comb begin
        wr_status = wr_en && (reg_sel_e'(wr_sel) == SEL_STATUS);
        wr_mask   = wr_en && (reg_sel_e'(wr_sel) == SEL_MASK);
        clr_vec   = wr_status ? wr_data : '0;
    end

    // Per-channel receive set terms, gated by the current mask.
    for (genvar c = 0; c < N_CH; c++) begin : g_rx
        always_comb begin
            rx_set[tx_pos(c)]            = 1'b0;
            rx_set[rx_pos(c)]            = rx_evt[c] && imr_q[rx_pos(c)];
            rx_set[tx_pos(c)+2]          = 1'b0;
            rx_set[tx_pos(c)+3]          = 1'b0;
        end
    end

    // Synthesised transmit-ready set: all TX bits together when any TX is enabled.
    always_comb tx_set = (tx_fire && |(imr_q & TXM)) ? TXM : '0;

    // Status register: clear written ones, then apply sets (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= ((isr_q & ~clr_vec) | rx_set | tx_set) & VALID;
    end

    // Mask register: load on a mask write.
    always_ff @(posedge clk) begin
        if (!rst_n)       imr_q <= '0;
        else if (wr_mask) imr_q <= wr_data & VALID;
    end

    // R4
    rx_a_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!isr_q[rx_pos(0)] && !imr_q[rx_pos(0)]) |=> !isr_q[rx_pos(0)]);
    // R10
    rx_b_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt[1] && imr_q[rx_pos(1)]) |=> isr_q[rx_pos(1)]);
    // R5
    tx_pair_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isr_q[tx_pos(0)]) |-> isr_q[tx_pos(1)]);
    // R9
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (imr_q == ($past(wr_data) & VALID)));
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((isr_q | imr_q) & ~VALID) == '0);
endmodule

// File: rtl/uart_irq_chan_view.sv
// Per-channel status view: maps one channel's receive-ready and
// transmit-ready status bits onto that channel's status byte.
// Assumes CH < N_CH; purely combinational.
module uart_irq_chan_view
    import uart_irq_pkg::*;
#(
    parameter int CH = 0
) (
    input  logic [REG_W-1:0] isr_q,
    output logic [REG_W-1:0] stat
);
    // Place the two flags at their fixed byte positions.
    always_comb begin
        stat              = '0;
        stat[STAT_RX_POS] = isr_q[rx_pos(CH)];
        stat[STAT_TX_POS] = isr_q[tx_pos(CH)];
    end
endmodule

// File: rtl/uart_irq_agg.sv
// Top: two-channel UART interrupt aggregator. Combines the tick sequencer,
// the status/mask registers and the per-channel views; drives one level
// interrupt request. Assumes all inputs synchronous to clk.
module uart_irq_agg
    import uart_irq_pkg::*;
#(
    parameter int TICK_PERIOD = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_CH-1:0]       rx_evt,
    input  logic                  tick,
    input  logic                  wr_en,
    input  logic                  wr_sel,
    input  logic [REG_W-1:0]      wr_data,
    output logic [REG_W-1:0]      isr,
    output logic [REG_W-1:0]      imr,
    output logic [N_CH*REG_W-1:0] chan_stat,
    output logic                  irq
);
    logic fire;

    uart_irq_tick_seq #(.PERIOD(TICK_PERIOD)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .fire  (fire)
    );

    uart_irq_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_evt  (rx_evt),
        .tx_fire (fire),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .isr_q   (isr),
        .imr_q   (imr)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_view
        uart_irq_chan_view #(.CH(c)) u_view (
            .isr_q (isr),
            .stat  (chan_stat[c*REG_W +: REG_W])
        );
    end

    // Combined request: any pending status bit under an enabled mask bit.
    always_comb irq = |(isr & imr);

    // R7
    irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imr == '0) |-> !irq);
    // R3
    rx_a_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt[0] && imr[rx_pos(0)] && !wr_en) |=> irq);
endmodule

// File: tb/tb_uart_irq_agg.sv
module tb_uart_irq_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rx_evt = '0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  isr, imr;
    logic [15:0] chan_stat;
    logic        irq;

    int applied = 0;
    int bad = 0;
    bit done = 1'b0;

    // Bench model state, computed from the requirements.
    logic [7:0] isr_m, imr_m;
    int         cnt_m;

    always #5 clk = ~clk;

    uart_irq_agg dut (
        .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .tick(tick),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .isr(isr), .imr(imr), .chan_stat(chan_stat), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle at a falling edge, update the model at the rising edge.
    task automatic step(input logic [1:0] r, input logic t, input logic we,
                        input logic ws, input logic [7:0] d);
        logic [7:0] set_v, clr_v;
        bit fire;
        rx_evt = r; tick = t; wr_en = we; wr_sel = ws; wr_data = d;
        @(posedge clk);
        if (rst_n) begin
            set_v = 8'h00;
            if (r[0] && imr_m[1]) set_v |= 8'h02;
            if (r[1] && imr_m[5]) set_v |= 8'h20;
            fire = t && (cnt_m == 1);
            if (t) cnt_m = fire ? 0 : cnt_m + 1;
            if (fire && (imr_m[0] || imr_m[4])) set_v |= 8'h11;
            clr_v = (we && !ws) ? d : 8'h00;
            isr_m = ((isr_m & ~clr_v) | set_v) & 8'h33;
            if (we && ws) imr_m = d & 8'h33;
        end
        @(negedge clk);
        rx_evt = '0; tick = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    endtask

    task automatic check_all(input string tag);
        logic [7:0] ca, cb;
        ca = {5'b0, isr_m[0], 1'b0, isr_m[1]};
        cb = {5'b0, isr_m[4], 1'b0, isr_m[5]};
        chk({tag, " R3 R4 R5 R8 R10 isr"}, 32'(isr), 32'(isr_m));
        chk({tag, " R2 R9 imr"}, 32'(imr), 32'(imr_m));
        chk({tag, " R7 irq"}, 32'(irq), 32'(|(isr_m & imr_m)));
        chk({tag, " R11 chan_stat"}, 32'(chan_stat), 32'({cb, ca}));
    endtask

    function automatic logic [7:0] expand(input logic [3:0] m);
        return {2'b0, m[3], m[2], 2'b0, m[1], m[0]};
    endfunction

    initial begin
        isr_m = '0; imr_m = '0; cnt_m = 0;
        @(negedge clk); @(negedge clk);
        // R1: reset values, even with stimulus applied during reset
        step(2'b11, 1'b1, 1'b1, 1'b1, 8'hFF);
        chk("R1 isr", 32'(isr), 0);
        chk("R1 imr", 32'(imr), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 chan_stat", 32'(chan_stat), 0);
        rst_n = 1'b1;

        // R2: reserved bits ignored on mask write
        step(2'b00, 1'b0, 1'b1, 1'b1, 8'hFF);
        chk("R2 mask reserved", 32'(imr), 32'h33);
        // R4: masked receive leaves status unchanged
        step(2'b00, 1'b0, 1'b1, 1'b1, 8'h11);
        step(2'b11, 1'b0, 1'b0, 1'b0, 8'h00);
        chk("R4 masked rx", 32'(isr), 0);
        // R6: first tick no fire, second tick fires but TX masked
        step(2'b00, 1'b0, 1'b1, 1'b1, 8'h22);
        step(2'b00, 1'b1, 1'b0, 1'b0, 8'h00);
        step(2'b00, 1'b1, 1'b0, 1'b0, 8'h00);
        chk("R6 tx masked", 32'(isr), 0);
        // R5: count wrapped, so next tick pair fires with TX B enabled only
        step(2'b00, 1'b0, 1'b1, 1'b1, 8'h10);
        step(2'b00, 1'b1, 1'b0, 1'b0, 8'h00);
        chk("R5 first tick", 32'(isr), 0);
        step(2'b00, 1'b0, 1'b0, 1'b0, 8'h00);
        step(2'b00, 1'b1, 1'b0, 1'b0, 8'h00);
        chk("R5 both tx set", 32'(isr), 32'h11);
        chk("R7 irq tx", 32'(irq), 1);
        // R8: clear only A TX bit
        step(2'b00, 1'b0, 1'b1, 1'b0, 8'h01);
        chk("R8 w1c partial", 32'(isr), 32'h10);
        chk("R7 irq held", 32'(irq), 1);
        step(2'b00, 1'b0, 1'b1, 1'b0, 8'h10);
        chk("R7 irq cleared", 32'(irq), 0);
        // R9: rx in same cycle as mask enable uses old mask
        step(2'b01, 1'b0, 1'b1, 1'b1, 8'h02);
        chk("R9 old mask", 32'(isr), 0);
        // R3 and R10: set beats clear
        step(2'b01, 1'b0, 1'b1, 1'b0, 8'h02);
        chk("R10 set wins", 32'(isr), 32'h02);
        chk("R3 irq", 32'(irq), 1);
        chk("R11 chan A rx", 32'(chan_stat), 32'h0001);

        // Reseed the model from the known state and sweep.
        isr_m = 8'h02; imr_m = 8'h02; cnt_m = 0;
        for (int m = 0; m < 16; m++) begin
            for (int r = 0; r < 4; r++) begin
                for (int t = 0; t < 2; t++) begin
                    for (int w = 0; w < 4; w++) begin
                        step(2'b00, 1'b0, 1'b1, 1'b1, expand(4'(m)));
                        check_all("sweep mask");
                        case (w)
                            0: step(2'(r), 1'(t), 1'b0, 1'b0, 8'h00);
                            1: step(2'(r), 1'(t), 1'b1, 1'b0, 8'hFF);
                            2: step(2'(r), 1'(t), 1'b1, 1'b0, 8'h22);
                            default: step(2'(r), 1'(t), 1'b1, 1'b1, expand(4'(15 - m)));
                        endcase
                        check_all("sweep evt");
                    end
                end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end
endmodule